// File: doc/BRIEF.md
# Watchdog-Served Operating Mode Controller

This block sits behind a serial host interface of a system supervisor. It receives complete 16-bit register frames on a valid/ready stream and acts on the frames aimed at the mode register. Each such frame either only selects which status word the host reads back, or also writes the mode register. A write is checked for a legal operating-mode code, a legal watchdog period field and a clear reserved bit. A legal write moves the controller between its operating modes and updates the enable output and the software-development flag. An illegal write is dropped and turns into a forced system reset.

After every reset the controller sits in a start-up state with a service window of `WIN_CYC` clock cycles. The first legal write must arrive inside that window, or the controller forces a reset. Flash programming is reachable only through a protected path. The host writes Normal, Flash, Normal, Flash as consecutive legal writes. The last of these forces a reset tagged as flash entry. An initialize-Flash write inside the following start-up window then enters Flash mode. Every forced reset raises a one-cycle request and loads a 4-bit reset-source code that stays until the next forced reset.

Frame stream rules: a frame transfers on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high in every cycle except the single cycle in which `rst_req_o` is high. A source that holds a frame during that cycle keeps it until the frame is taken. No frame is ever dropped for back-pressure.

Top module: `opm_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_o` is 000 (start-up), `en_o`, `sdm_o`, `rd_diag_o` and `rst_req_o` are 0, `rst_src_o` is 0000 (power-on) and `wr_ready` is 1.
- R2: A frame whose bits 15:14 are not 00 is accepted and changes no output.
- R3: A frame with bits 15:14 = 00 copies bit 13 to `rd_diag_o` unless it is dropped as illegal. If bit 12 is 1, the frame is read-only: it leaves mode, enable and flag unchanged, is not checked and does not serve the window.
- R4: A legal write (bits 15:14 = 00, bit 12 = 0) sets `en_o` from bit 1 and `sdm_o` from bit 2. The new values are visible one cycle after the transfer.
- R5: The mode code sits in bits 5:3. In start-up, code 101 enters Normal (001). In Normal, Standby (010) and Sleep (100), codes 001 and 101 select Normal, 010 selects Standby and 100 selects Sleep.
- R6: A write is illegal and forces a reset if any of these holds: code 000, bit 0 set, a period field (bits 11:6) of `WD_PERIODS` (48) or above, or a code that the current mode does not allow. The frame is dropped. The cycle after the transfer shows `rst_req_o` = 1, `rst_src_o` = 0001, `mode_o` = 000, and `en_o` = `sdm_o` = 0.
- R7: If no legal write arrives within `WIN_CYC` cycles in start-up, a reset is forced with `rst_src_o` = 0010. Once a legal write has left start-up, idle time causes no reset.
- R8: The consecutive legal writes 001, 111, 001, 111 in the operating modes force a reset with `rst_src_o` = 0011. The first 111 of the sequence keeps the mode at Normal.
- R9: Code 011 enters Flash (111) only in the start-up window that follows a 0011 reset. Anywhere else it is illegal. A timeout in that window removes the permission.
- R10: Any other legal write in the middle of the sequence restarts it. A 111 written when the sequence does not expect it is illegal.
- R11: In Flash mode only code 110 is legal, and it returns to Normal. Every other code is illegal.
- R12: `rst_req_o` is high for exactly one cycle per forced reset. `wr_ready` is low in that cycle and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Frame present on `wr_data` |
| wr_ready | output | 1 | Frame can be taken this cycle |
| wr_data | input | 16 | Decoded register frame |
| mode_o | output | 3 | Current operating mode code (000 start-up) |
| en_o | output | 1 | Enable output level |
| sdm_o | output | 1 | Software-development flag |
| rd_diag_o | output | 1 | Read-back select: 1 diagnosis word, 0 status word |
| rst_req_o | output | 1 | One-cycle forced system reset request |
| rst_src_o | output | 4 | Cause of the latest reset |

## Verification
A wrong mode state appears at the ports no later than the next write. That write is then either rejected with a reset pulse that should not happen, or accepted when it should be rejected, and the reset source shows which of the two occurred. A sequence tracker that is off by one step either fires the flash-entry reset one write early or late, or declares the closing 111 illegal, so `rst_src_o` reads 0001 instead of 0011 on the very next cycle. A window counter of the wrong length shows up as a 0010 reset pulse at the wrong cycle, or as no pulse at all.

// File: rtl/opm_pkg.sv
package opm_pkg;
  typedef enum logic [2:0] {
    M_START  = 3'b000,
    M_NORMAL = 3'b001,
    M_STBY   = 3'b010,
    M_SLEEP  = 3'b100,
    M_FLASH  = 3'b111
  } opm_mode_e;

  localparam logic [2:0] C_NORMAL   = 3'b001;
  localparam logic [2:0] C_STBY     = 3'b010;
  localparam logic [2:0] C_INIT_FL  = 3'b011;
  localparam logic [2:0] C_SLEEP    = 3'b100;
  localparam logic [2:0] C_INIT_NM  = 3'b101;
  localparam logic [2:0] C_LEAVE_FL = 3'b110;
  localparam logic [2:0] C_FLASH    = 3'b111;

  localparam logic [3:0] SRC_POR     = 4'h0;
  localparam logic [3:0] SRC_ILLEGAL = 4'h1;
  localparam logic [3:0] SRC_TIMEOUT = 4'h2;
  localparam logic [3:0] SRC_FLASH   = 4'h3;

  typedef struct packed {
    logic [1:0] addr;
    logic       rd_diag;
    logic       rd_only;
    logic [5:0] period;
    logic [2:0] code;
    logic       sdm;
    logic       en;
    logic       rsv;
  } opm_frame_t;
endpackage

// File: rtl/opm_frame_dec.sv
module opm_frame_dec
  import opm_pkg::*;
#(
  parameter int WD_PERIODS = 48
) (
  input  logic        xfer,
  input  logic [15:0] data,
  output logic        acc_mode,
  output logic        acc_write,
  output logic        rd_diag,
  output logic [2:0]  code,
  output logic        en_bit,
  output logic        sdm_bit,
  output logic        fmt_bad
);
  localparam logic [5:0] PER_LIM = 6'(WD_PERIODS);

  opm_frame_t f;
  assign f = opm_frame_t'(data);

  assign acc_mode  = xfer && (f.addr == 2'b00);
  assign acc_write = acc_mode && !f.rd_only;
  assign rd_diag   = f.rd_diag;
  assign code      = f.code;
  assign en_bit    = f.en;
  assign sdm_bit   = f.sdm;
  assign fmt_bad   = f.rsv || (f.code == 3'b000) || (f.period >= PER_LIM);
endmodule

// File: rtl/opm_win_timer.sv
module opm_win_timer #(
  parameter int WIN_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hit,
  input  logic clr,
  output logic expire
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST) && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr || !run || hit) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R7: the counter never passes the last window cycle
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/opm_flash_seq.sv
module opm_flash_seq
  import opm_pkg::*;
#(
  parameter int SEQ_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [2:0] code,
  output logic       step_ok,
  output logic       fire_ok
);
  localparam int PW = $clog2(SEQ_LEN + 1);
  localparam logic [PW-1:0] LAST = PW'(SEQ_LEN - 1);

  logic [PW-1:0] pos_q;

  assign fire_ok = (pos_q == LAST);
  assign step_ok = pos_q[0] && !fire_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (clr) pos_q <= '0;
    else if (upd) begin
      if (code == C_NORMAL) pos_q <= pos_q[0] ? PW'(1) : pos_q + 1'b1;
      else if (code == C_FLASH) pos_q <= pos_q + 1'b1;
      else pos_q <= '0;
    end
  end

  // R8: a flash step only advances from an odd position
  p_step_from_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !clr && (code == C_FLASH) |-> pos_q[0]);
  // R10: any other code empties the tracker
  p_break_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !clr && (code != C_FLASH) && (code != C_NORMAL) |=> (pos_q == '0));
endmodule

// File: rtl/opm_mode_ctrl.sv
module opm_mode_ctrl
  import opm_pkg::*;
#(
  parameter int WIN_CYC    = 64,
  parameter int SEQ_LEN    = 4,
  parameter int WD_PERIODS = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [15:0] wr_data,
  output logic [2:0]  mode_o,
  output logic        en_o,
  output logic        sdm_o,
  output logic        rd_diag_o,
  output logic        rst_req_o,
  output logic [3:0]  rst_src_o
);
  opm_mode_e  mode_q, nx_mode;
  logic       en_q, sdm_q, rd_q, req_q, armed_q;
  logic [3:0] src_q, nx_src;

  logic       acc_mode, acc_write, f_rd, f_en, f_sdm, fmt_bad;
  logic [2:0] f_code;
  logic       illegal, fire, init_hit, seq_upd, expire, force_rst;
  logic       step_ok, fire_ok;

  assign wr_ready = !req_q;

  opm_frame_dec #(.WD_PERIODS(WD_PERIODS)) u_dec (
    .xfer(wr_valid && wr_ready), .data(wr_data),
    .acc_mode(acc_mode), .acc_write(acc_write), .rd_diag(f_rd),
    .code(f_code), .en_bit(f_en), .sdm_bit(f_sdm), .fmt_bad(fmt_bad)
  );

  opm_flash_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(force_rst), .upd(seq_upd),
    .code(f_code), .step_ok(step_ok), .fire_ok(fire_ok)
  );

  opm_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .run(mode_q == M_START),
    .hit(init_hit), .clr(force_rst), .expire(expire)
  );

  always_comb begin
    nx_mode  = mode_q;
    illegal  = 1'b0;
    fire     = 1'b0;
    init_hit = 1'b0;
    seq_upd  = 1'b0;
    if (acc_write) begin
      if (fmt_bad) illegal = 1'b1;
      else begin
        case (mode_q)
          M_START: begin
            if (f_code == C_INIT_NM) begin
              nx_mode  = M_NORMAL;
              init_hit = 1'b1;
            end else if (f_code == C_INIT_FL && armed_q) begin
              nx_mode  = M_FLASH;
              init_hit = 1'b1;
            end else illegal = 1'b1;
          end
          M_FLASH: begin
            if (f_code == C_LEAVE_FL) nx_mode = M_NORMAL;
            else illegal = 1'b1;
          end
          default: begin
            case (f_code)
              C_NORMAL, C_INIT_NM: nx_mode = M_NORMAL;
              C_STBY:              nx_mode = M_STBY;
              C_SLEEP:             nx_mode = M_SLEEP;
              C_FLASH: begin
                if (fire_ok) fire = 1'b1;
                else if (!step_ok) illegal = 1'b1;
              end
              default: illegal = 1'b1;
            endcase
            seq_upd = !illegal && !fire;
          end
        endcase
      end
    end
  end

  assign force_rst = illegal || fire || expire;

  always_comb begin
    if (fire) nx_src = SRC_FLASH;
    else if (illegal) nx_src = SRC_ILLEGAL;
    else nx_src = SRC_TIMEOUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_START;
      en_q    <= 1'b0;
      sdm_q   <= 1'b0;
      rd_q    <= 1'b0;
      req_q   <= 1'b0;
      src_q   <= SRC_POR;
      armed_q <= 1'b0;
    end else begin
      req_q <= force_rst;
      if (acc_mode && !illegal) rd_q <= f_rd;
      if (force_rst) begin
        mode_q  <= M_START;
        en_q    <= 1'b0;
        sdm_q   <= 1'b0;
        src_q   <= nx_src;
        armed_q <= fire;
      end else begin
        if (acc_write) begin
          mode_q <= nx_mode;
          en_q   <= f_en;
          sdm_q  <= f_sdm;
        end
        if (init_hit) armed_q <= 1'b0;
      end
    end
  end

  assign mode_o    = mode_q;
  assign en_o      = en_q;
  assign sdm_o     = sdm_q;
  assign rd_diag_o = rd_q;
  assign rst_req_o = req_q;
  assign rst_src_o = src_q;

  // R12: request lasts one cycle and blocks the stream
  p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  p_ready_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !wr_ready);
  // R6: a forced reset lands in start-up with enable and flag cleared
  p_reset_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (mode_o == M_START) && !en_o && !sdm_o);
  // R6: the source only changes together with a request
  p_src_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rst_src_o) |-> rst_req_o);
  // R9: Flash is entered only from start-up
  p_flash_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_FLASH) && ($past(mode_o) != M_FLASH) |-> ($past(mode_o) == M_START));
  // R7: window expiry without a frame gives a timeout reset
  p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !acc_write |=> rst_req_o && (rst_src_o == SRC_TIMEOUT));
  // R2: other register addresses leave the mode untouched
  p_other_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && (wr_data[15:14] != 2'b00) && !expire |=> $stable(mode_o) && $stable(en_o));
endmodule

// File: tb/opm_mode_ctrl_tb.sv
`timescale 1ns/1ps
module opm_mode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic [2:0]  mode_o;
  logic        en_o, sdm_o, rd_diag_o, rst_req_o;
  logic [3:0]  rst_src_o;

  int checks = 0;
  int fails  = 0;

  logic [2:0] m_mode;
  logic       m_en, m_sdm, m_rd, m_armed;
  logic [3:0] m_src;
  int         m_pos;

  always #2.5 clk = ~clk;

  opm_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .mode_o(mode_o), .en_o(en_o), .sdm_o(sdm_o),
    .rd_diag_o(rd_diag_o), .rst_req_o(rst_req_o), .rst_src_o(rst_src_o)
  );

  function automatic logic [15:0] mk(input logic [2:0] code, input bit en,
                                     input bit sdm, input bit rd, input bit ro);
    logic [15:0] d;
    d = '0;
    d[13] = rd; d[12] = ro; d[11:6] = 6'd5;
    d[5:3] = code; d[2] = sdm; d[1] = en;
    return d;
  endfunction

  function automatic logic [15:0] rnd_frame(input logic [2:0] cur);
    logic [15:0] d;
    d = 16'($urandom);
    if ($urandom % 8 != 0) d[15:14] = 2'b00;
    d[12] = ($urandom % 8 == 0);
    d[0]  = ($urandom % 10 == 0);
    if (d[11:6] >= 6'd48 && ($urandom % 4 != 0)) d[11:6] = d[11:6] & 6'h1f;
    if ($urandom % 2 == 0) d[5:3] = ($urandom % 2 == 0) ? 3'b001 : 3'b111;
    if (cur == 3'b000) begin
      if ($urandom % 10 < 6) d[5:3] = 3'b101;
      else if ($urandom % 4 == 0) d[5:3] = 3'b011;
    end
    return d;
  endfunction

  task automatic model(input logic [15:0] d, output bit req);
    logic [2:0] c;
    bit ill, fi;
    req = 0; ill = 0; fi = 0;
    c = d[5:3];
    if (d[15:14] != 2'b00) return;
    if (d[12]) begin m_rd = d[13]; return; end
    if (d[0] || c == 3'b000 || d[11:6] >= 6'd48) ill = 1;
    else if (m_mode == 3'b000) begin
      if (c == 3'b101) m_mode = 3'b001;
      else if (c == 3'b011 && m_armed) m_mode = 3'b111;
      else ill = 1;
      if (!ill) m_armed = 0;
    end else if (m_mode == 3'b111) begin
      if (c == 3'b110) m_mode = 3'b001; else ill = 1;
    end else begin
      case (c)
        3'b001: begin m_mode = 3'b001; m_pos = (m_pos % 2 == 1) ? 1 : m_pos + 1; end
        3'b101: begin m_mode = 3'b001; m_pos = 0; end
        3'b010: begin m_mode = 3'b010; m_pos = 0; end
        3'b100: begin m_mode = 3'b100; m_pos = 0; end
        3'b111: begin
          if (m_pos == 3) fi = 1;
          else if (m_pos == 1) m_pos = 2;
          else ill = 1;
        end
        default: ill = 1;
      endcase
    end
    if (!ill) m_rd = d[13];
    if (ill || fi) begin
      req = 1; m_mode = 3'b000; m_en = 0; m_sdm = 0; m_pos = 0;
      m_src = fi ? 4'h3 : 4'h1; m_armed = fi;
    end else begin
      m_en = d[1]; m_sdm = d[2];
    end
  endtask

  task automatic chk_all(input string tag, input bit req);
    bit bad;
    bad = 0;
    checks++;
    if (rst_req_o !== req) begin bad = 1;
      $display("FAIL %s rst_req_o act=%0b exp=%0b", tag, rst_req_o, req); end
    if (wr_ready !== !req) begin bad = 1;
      $display("FAIL %s wr_ready act=%0b exp=%0b", tag, wr_ready, !req); end
    if (mode_o !== m_mode) begin bad = 1;
      $display("FAIL %s mode_o act=%b exp=%b", tag, mode_o, m_mode); end
    if (en_o !== m_en) begin bad = 1;
      $display("FAIL %s en_o act=%0b exp=%0b", tag, en_o, m_en); end
    if (sdm_o !== m_sdm) begin bad = 1;
      $display("FAIL %s sdm_o act=%0b exp=%0b", tag, sdm_o, m_sdm); end
    if (rd_diag_o !== m_rd) begin bad = 1;
      $display("FAIL %s rd_diag_o act=%0b exp=%0b", tag, rd_diag_o, m_rd); end
    if (rst_src_o !== m_src) begin bad = 1;
      $display("FAIL %s rst_src_o act=%h exp=%h", tag, rst_src_o, m_src); end
    if (bad) fails++;
  endtask

  task automatic send(input logic [15:0] d, input string tag);
    bit req;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    model(d, req);
    chk_all(tag, req);
    if (req) begin
      @(negedge clk);
      chk_all({tag, " pulse end R12"}, 1'b0);
    end
  endtask

  task automatic idle_count(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_req_o) pulses++;
    end
  endtask

  task automatic flash_seq(input string tag);
    send(mk(3'b001, 0, 0, 0, 0), tag);
    send(mk(3'b111, 0, 0, 0, 0), tag);
    send(mk(3'b001, 0, 0, 0, 0), tag);
    send(mk(3'b111, 0, 0, 0, 0), tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end act=hung exp=done");
    finish_run();
  end

  initial begin
    int p;
    logic [15:0] d;
    void'($urandom(32'd20240611));
    m_mode = 3'b000; m_en = 0; m_sdm = 0; m_rd = 0; m_src = 4'h0;
    m_armed = 0; m_pos = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset state", 1'b0);

    send(mk(3'b101, 1, 0, 0, 0), "R5 init normal");
    d = mk(3'b010, 0, 1, 1, 0); d[15:14] = 2'b01;
    send(d, "R2 other address");
    send(mk(3'b000, 0, 1, 1, 1), "R3 read only");
    send(mk(3'b010, 1, 1, 0, 0), "R4 standby with flag");
    send(mk(3'b100, 0, 1, 1, 0), "R5 sleep");
    send(mk(3'b101, 1, 0, 0, 0), "R5 init normal from sleep");

    send(mk(3'b000, 1, 0, 0, 0), "R6 code 000");
    send(mk(3'b101, 0, 0, 0, 0), "R5 init normal");
    d = mk(3'b001, 1, 0, 0, 0); d[0] = 1'b1;
    send(d, "R6 reserved bit");
    send(mk(3'b101, 0, 0, 0, 0), "R5 init normal");
    d = mk(3'b001, 1, 0, 0, 0); d[11:6] = 6'd48;
    send(d, "R6 period field");
    send(mk(3'b101, 0, 0, 0, 0), "R5 init normal");

    send(mk(3'b111, 0, 0, 0, 0), "R10 flash without lead");
    send(mk(3'b101, 0, 0, 0, 0), "R5 init normal");
    send(mk(3'b001, 0, 0, 0, 0), "R10 seq step");
    send(mk(3'b111, 0, 0, 0, 0), "R8 first flash keeps normal");
    send(mk(3'b010, 0, 0, 0, 0), "R10 break by standby");
    send(mk(3'b111, 0, 0, 0, 0), "R10 flash after break");
    send(mk(3'b101, 0, 0, 0, 0), "R5 init normal");

    send(mk(3'b011, 0, 0, 0, 0), "R9 init flash in op mode");
    send(mk(3'b011, 0, 0, 0, 0), "R9 init flash not armed");
    send(mk(3'b101, 0, 0, 0, 0), "R5 init normal");

    flash_seq("R8 sequence");
    send(mk(3'b011, 1, 0, 0, 0), "R9 enter flash");
    send(mk(3'b001, 0, 0, 0, 0), "R11 normal in flash");
    send(mk(3'b101, 0, 0, 0, 0), "R5 init normal");
    flash_seq("R8 sequence again");
    send(mk(3'b011, 0, 0, 1, 0), "R9 enter flash");
    send(mk(3'b110, 1, 0, 0, 0), "R11 leave flash");

    idle_count(100, p);
    checks++;
    if (p != 0) begin fails++;
      $display("FAIL R7 idle in normal pulses act=%0d exp=0", p); end

    flash_seq("R8 sequence before timeout");
    idle_count(70, p);
    checks++;
    if (p != 1) begin fails++;
      $display("FAIL R7 timeout pulses act=%0d exp=1", p); end
    m_src = 4'h2; m_armed = 0;
    chk_all("R7 timeout source", 1'b0);
    send(mk(3'b011, 0, 0, 0, 0), "R9 permission gone after timeout");
    send(mk(3'b101, 0, 0, 0, 0), "R5 init normal");

    for (int i = 0; i < 400; i++) begin
      send(rnd_frame(m_mode), "R5/R6/R8/R10 random");
    end

    finish_run();
  end
endmodule